// File: doc/BRIEF.md
# Memory-Access Instruction Classifier

This combinational decoder looks at one fetched instruction word and reports whether it is an integer or floating-point load or store. Both the 16-bit compressed forms and the 32-bit forms are recognised. A trap handler for misaligned accesses can use the result to replay the access byte by byte. For a recognised word the block returns the instruction length, the direction, whether the data is floating-point, the access size in bytes, whether a loaded value is sign-extended, and the 5-bit register number. Any other word raises `trap_redirect` so that the exception can be passed on.

Parameter `XLEN` (32 or 64) selects which meaning applies to the compressed funct3 codes 011 and 111. Parameter `FP_EN` decides whether floating-point forms are accepted or sent to the trap path.

Top module: `mem_insn_classifier`

## Requirements
- R1: A word with bits [1:0] != 2'b11 is 16 bits long and gives `insn_bytes` = 2. A word with bits [1:0] = 2'b11 and bits [4:2] != 3'b111 is 32 bits long and gives `insn_bytes` = 4. A word with bits [1:0] = 2'b11 and bits [4:2] = 3'b111 always traps.
- R2: When a word is not recognised, `trap_redirect` = 1 and `hit` = 0, and every other output is zero. When a word is recognised, `hit` = 1 and `trap_redirect` = 0.
- R3: Quadrant 0 (bits [1:0] = 2'b00) uses funct3 in bits [15:13]. 010 is a signed 4-byte load and 110 is a 4-byte store. 001 is an 8-byte FP load and 101 is an 8-byte FP store. For 011 and 111: with XLEN=64 they are a signed 8-byte load and an 8-byte store; with XLEN=32 they are a 4-byte FP load and a 4-byte FP store. 000 and 100 trap. The register is 8 + bits [4:2].
- R4: Quadrant 2 (bits [1:0] = 2'b10) is stack-relative and uses the same funct3 meanings as R3. Loads take the register from bits [11:7] and stores take it from bits [6:2]. 000 and 100 trap.
- R5: Every quadrant 1 word (bits [1:0] = 2'b01) traps.
- R6: Opcode 7'b0000011 with funct3 in bits [14:12] decodes as follows. 000, 001, 010 and 011 are signed loads of 1, 2, 4 and 8 bytes; 011 is accepted only with XLEN=64. 100, 101 and 110 are unsigned loads of 1, 2 and 4 bytes. 111 traps. The register comes from bits [11:7].
- R7: Opcode 7'b0100011 decodes as stores: funct3 000 is 1 byte, 001 is 2 bytes, 010 is 4 bytes and 011 is 8 bytes (XLEN=64 only). The other funct3 values trap. The register comes from bits [24:20]. Stores are never sign-extended.
- R8: Opcode 7'b0000111 is an FP load and opcode 7'b0100111 is an FP store. Funct3 010 is 4 bytes and 011 is 8 bytes; other funct3 values trap. Loads take the register from [11:7] and stores from [24:20]. No FP access is sign-extended.
- R9: With FP_EN=0, every word that would decode as floating-point traps.
- R10: Any 32-bit opcode not named in R6 to R8 traps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word; a compressed word sits in bits [15:0] |
| hit | output | 1 | Word is a recognised load or store |
| trap_redirect | output | 1 | Word is not handled and the trap must be passed on |
| insn_bytes | output | 3 | Instruction length in bytes (2 or 4), 0 on trap |
| is_load | output | 1 | 1 for a load, 0 for a store |
| is_fp | output | 1 | Floating-point data |
| acc_bytes | output | 4 | Access size in bytes (1, 2, 4 or 8) |
| sign_ext | output | 1 | Loaded value must be sign-extended |
| reg_idx | output | 5 | Destination register (load) or source register (store) |

## Verification
The bench builds two copies of the block and drives both with the same words. One copy uses XLEN=64 with FP_EN=1. The other uses XLEN=32 with FP_EN=0, so funct3 011/111 in both compressed quadrants is exercised under both meanings, and the path where FP words are rejected is exercised too. Every quadrant and funct3 pair, and every 32-bit opcode class with every funct3, is stepped through exhaustively. After that come random words, biased toward the opcode fields that decode.

// File: rtl/mem_insn_classifier.sv
module mem_insn_classifier #(
  parameter int XLEN  = 64,
  parameter bit FP_EN = 1'b1
) (
  input  logic [31:0] insn,
  output logic        hit,
  output logic        trap_redirect,
  output logic [2:0]  insn_bytes,
  output logic        is_load,
  output logic        is_fp,
  output logic [3:0]  acc_bytes,
  output logic        sign_ext,
  output logic [4:0]  reg_idx
);

  localparam bit WIDE = (XLEN >= 64);

  logic       short_w, long_w;
  logic [2:0] cf3, wf3;
  logic [6:0] op;

  assign short_w = insn[1:0] != 2'b11;
  assign long_w  = (insn[1:0] == 2'b11) && (insn[4:2] != 3'b111);
  assign cf3     = insn[15:13];
  assign wf3     = insn[14:12];
  assign op      = insn[6:0];

  logic       m, ld, fp, sx;
  logic [3:0] w;
  logic [4:0] r;

  always_comb begin
    m = 1'b0; ld = 1'b0; fp = 1'b0; sx = 1'b0; w = 4'd0; r = 5'd0;
    if (short_w) begin
      if ((insn[1:0] == 2'b00 || insn[1:0] == 2'b10) && cf3[1:0] != 2'b00) begin
        m  = 1'b1;
        ld = !cf3[2];
        case (cf3[1:0])
          2'b01:   begin fp = 1'b1; w = 4'd8; end
          2'b10:   w = 4'd4;
          default: begin
            if (WIDE) w = 4'd8;
            else begin fp = 1'b1; w = 4'd4; end
          end
        endcase
        sx = ld && !fp;
        if (insn[1:0] == 2'b00) r = {2'b01, insn[4:2]};
        else if (ld)            r = insn[11:7];
        else                    r = insn[6:2];
      end
    end else if (long_w) begin
      case (op)
        7'b0000011: begin
          ld = 1'b1;
          r  = insn[11:7];
          sx = !wf3[2];
          case (wf3[1:0])
            2'b00: w = 4'd1;
            2'b01: w = 4'd2;
            2'b10: w = 4'd4;
            default: w = 4'd8;
          endcase
          m = (wf3 != 3'b111) && (wf3 != 3'b011 || WIDE);
        end
        7'b0100011: begin
          r = insn[24:20];
          case (wf3)
            3'b000: begin m = 1'b1; w = 4'd1; end
            3'b001: begin m = 1'b1; w = 4'd2; end
            3'b010: begin m = 1'b1; w = 4'd4; end
            3'b011: begin m = WIDE; w = 4'd8; end
            default: m = 1'b0;
          endcase
        end
        7'b0000111, 7'b0100111: begin
          fp = 1'b1;
          ld = !op[5];
          r  = op[5] ? insn[24:20] : insn[11:7];
          m  = (wf3 == 3'b010) || (wf3 == 3'b011);
          w  = wf3[0] ? 4'd8 : 4'd4;
        end
        default: m = 1'b0;
      endcase
    end
  end

  logic ok;
  assign ok = m && (FP_EN || !fp);

  assign hit           = ok;
  assign trap_redirect = !ok;
  assign insn_bytes    = !ok ? 3'd0 : (short_w ? 3'd2 : 3'd4);
  assign is_load       = ok && ld;
  assign is_fp         = ok && fp;
  assign acc_bytes     = ok ? w : 4'd0;
  assign sign_ext      = ok && sx;
  assign reg_idx       = ok ? r : 5'd0;

  always_comb begin
    if (!$isunknown(insn)) begin
      a_r1_len_match: assert (!hit || insn_bytes == ((insn[1:0] == 2'b11) ? 3'd4 : 3'd2))
        else $error("R1 length disagrees with low bits");
      a_r1_reserved_len: assert (!(insn[1:0] == 2'b11 && insn[4:2] == 3'b111) || trap_redirect)
        else $error("R1 reserved length accepted");
      a_r2_trap_quiet: assert (!trap_redirect ||
                               ({insn_bytes, is_load, is_fp, acc_bytes, sign_ext, reg_idx} == '0))
        else $error("R2 trap with nonzero outputs");
      a_r2_width_onehot: assert (!hit || $onehot(acc_bytes))
        else $error("R2 access width not a power of two");
      a_r3_creg_offset: assert (!(hit && insn[1:0] == 2'b00) || reg_idx[4:3] == 2'b01)
        else $error("R3 compressed register outside x8..x15");
      a_r5_quadrant1: assert (insn[1:0] != 2'b01 || trap_redirect)
        else $error("R5 quadrant 1 accepted");
      a_r8_fp_unsigned: assert (!(is_fp && sign_ext))
        else $error("R8 FP access sign-extended");
      a_r7_store_unsigned: assert (!(hit && !is_load && sign_ext))
        else $error("R7 store sign-extended");
      a_r9_fp_gate: assert (FP_EN || !is_fp)
        else $error("R9 FP accepted while disabled");
    end
  end

endmodule

// File: tb/test_mem_insn_classifier.sv
`timescale 1ns/1ps
module test_mem_insn_classifier;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] insn = 32'd0;

  logic       h64, t64, l64, f64, s64;
  logic [2:0] b64;
  logic [3:0] w64;
  logic [4:0] r64;
  logic       h32, t32, l32, f32, s32;
  logic [2:0] b32;
  logic [3:0] w32;
  logic [4:0] r32;

  mem_insn_classifier #(.XLEN(64), .FP_EN(1'b1)) i_mem_insn_classifier (
    .insn(insn), .hit(h64), .trap_redirect(t64), .insn_bytes(b64), .is_load(l64),
    .is_fp(f64), .acc_bytes(w64), .sign_ext(s64), .reg_idx(r64));

  mem_insn_classifier #(.XLEN(32), .FP_EN(1'b0)) i_mem_insn_classifier_32 (
    .insn(insn), .hit(h32), .trap_redirect(t32), .insn_bytes(b32), .is_load(l32),
    .is_fp(f32), .acc_bytes(w32), .sign_ext(s32), .reg_idx(r32));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  function automatic logic [16:0] model(input logic [31:0] x, input bit rv64, input bit fpe);
    bit ok = 0, ld = 0, fp = 0, sx = 0;
    int ln = 0, wd = 0, rg = 0;
    int q = x[1:0];
    int f;
    int opc = x[6:0];
    if (q != 3) begin
      ln = 2;
      f = x[15:13];
      if ((q == 0 || q == 2) && f != 0 && f != 4) begin
        ok = 1;
        ld = (f < 4);
        if (f % 4 == 1) begin fp = 1; wd = 8; end
        else if (f % 4 == 2) wd = 4;
        else if (rv64) wd = 8;
        else begin fp = 1; wd = 4; end
        sx = ld && !fp;
        if (q == 0) rg = 8 + x[4:2];
        else rg = ld ? x[11:7] : x[6:2];
      end
    end else if (x[4:2] != 3'b111) begin
      ln = 4;
      f = x[14:12];
      if (opc == 3) begin
        ld = 1; rg = x[11:7]; wd = 1 << (f % 4); sx = (f < 4);
        ok = (f != 7) && (f != 3 || rv64);
      end else if (opc == 35) begin
        rg = x[24:20]; wd = 1 << (f % 4);
        ok = (f < 3) || (f == 3 && rv64);
      end else if (opc == 7 || opc == 39) begin
        fp = 1; ld = (opc == 7);
        rg = ld ? x[11:7] : x[24:20];
        wd = (f == 2) ? 4 : 8;
        ok = (f == 2 || f == 3);
      end
    end
    if (fp && !fpe) ok = 0;
    if (!ok) return {1'b0, 1'b1, 15'd0};
    return {1'b1, 1'b0, 3'(ln), ld, fp, 4'(wd), sx, 5'(rg)};
  endfunction

  function automatic string tag_of(input logic [31:0] x, input logic [16:0] e, input bit fpe);
    if (x[1:0] == 2'b11 && x[4:2] == 3'b111) return "R1";
    if (x[1:0] == 2'b01) return "R5";
    if (e[15]) begin
      if (!fpe && (x[6:0] == 7'h07 || x[6:0] == 7'h27 ||
                   (x[1:0] != 2'b11 && x[1] == x[0] && x[15:13] != 3'b000 && x[15:13] != 3'b100)))
        return "R9";
      if (x[1:0] == 2'b11 && x[6:0] != 7'h03 && x[6:0] != 7'h23 &&
          x[6:0] != 7'h07 && x[6:0] != 7'h27) return "R10";
      return "R2";
    end
    if (x[1:0] == 2'b00) return "R3";
    if (x[1:0] == 2'b10) return "R4";
    if (x[6:0] == 7'h03) return "R6";
    if (x[6:0] == 7'h23) return "R7";
    return "R8";
  endfunction

  task automatic check_one(input string name, input logic [16:0] act, input logic [16:0] exp,
                           input bit fpe);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s insn=%08h actual=%05h expected=%05h",
               tag_of(insn, exp, fpe), name, insn, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] v);
    @(posedge clk);
    insn <= v;
    @(negedge clk);
    check_one("rv64", {h64, t64, b64, l64, f64, w64, s64, r64}, model(v, 1, 1), 1'b1);
    check_one("rv32", {h32, t32, b32, l32, f32, w32, s32, r32}, model(v, 0, 0), 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n <= 1'b1;
    // Reset state: an all-zero word is an illegal quadrant 0 form (R2)
    apply(32'h0000_0000);
    // R3, R4, R5: every quadrant / funct3 pair with varied register fields
    for (int q = 0; q < 3; q++)
      for (int f = 0; f < 8; f++) begin
        apply({16'h0000, 3'(f), 1'b0, 5'd13, 5'd22, 2'(q)});
        apply({16'hFFFF, 3'(f), 1'b1, 5'd3, 5'd29, 2'(q)});
      end
    // R6, R7, R8, R10: 32-bit opcode classes times funct3
    for (int k = 0; k < 6; k++)
      for (int f = 0; f < 8; f++) begin
        logic [6:0] oc;
        case (k)
          0: oc = 7'h03;
          1: oc = 7'h23;
          2: oc = 7'h07;
          3: oc = 7'h27;
          4: oc = 7'h13;
          default: oc = 7'h1F;
        endcase
        apply({7'h55, 5'd31, 5'd6, 3'(f), 5'd17, oc});
        apply({7'h00, 5'd1, 5'd30, 3'(f), 5'd0, oc});
      end
    // R1: reserved length forms
    apply(32'h0000_201F);
    apply(32'hFFFF_FFFF);
    // Random, biased toward decodable fields
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] v;
      v = $urandom;
      case ($urandom % 8)
        0: ;
        1: v[1:0] = 2'b00;
        2: v[1:0] = 2'b10;
        3: v[6:0] = 7'h03;
        4: v[6:0] = 7'h23;
        5: v[6:0] = 7'h07;
        6: v[6:0] = 7'h27;
        default: v[1:0] = 2'b11;
      endcase
      apply(v);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule